// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Enable Registers

This block keeps the event bookkeeping of a memory-card host controller. Single-cycle pulses from the controller's datapath set sticky bits in a 32-bit status word. Software reads that word over a simple register bus and clears any sticky bit by writing a 1 to its position. Some positions are not sticky: they show live levels from the data buffers and from the card bus clock. A two-bit result code, captured together with a write-CRC error, tells a missing CRC status token apart from a CRC mismatch.

A 19-bit interrupt-enable register chooses which pending events drive the single interrupt line. The line is registered. The block also drives a combinational error summary for the response and data error bits. Each register is written in the same cycle that the write strobe is seen. Reads are combinational from the address.

Top module: `card_event_regs`

## Requirements
- R1: After reset all sticky status bits, the write-CRC code, the enable register and `irqOut` are 0.
- R2: A 1 on `evtPulse` at a sticky position (31, 30, 25, 24, 14, 13, 12, 11, 7, 6, 5, 3, 2, 1, 0) sets that status bit at the next clock edge. The bit then stays set until it is cleared.
- R3: A status write clears each sticky bit that has a 1 in the write data and leaves the other bits alone. Writing back a value just read clears every event bit that was set in it.
- R4: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 29, 28, 27 and 26 show `bufLevel[3:0]` live, and bit 8 shows `busClkRun` live. Writes do not change them. Event pulses at non-sticky positions (level bits, bits 10:9, bit 4, bits 23:15) have no effect.
- R6: Status bits [10:9] take `wcrcCodeIn` in the cycle that bit 2 is set by an event, and return to 0 when bit 2 is cleared. `wcrcNoToken` is high when bit 2 is set and the code is 2. `wcrcMismatch` is high when bit 2 is set and the code is 1 or 3.
- R7: `errSummary` is the OR of status bits 0, 1, 2, 3 and 5.
- R8: A write to the enable register stores bits [18:0] of the write data. A read returns them with bits 31:19 as 0.
- R9: Enable bits 0, 1, 2, 3, 4, 13, 14 and 15 gate status bits 11, 12, 13, 6, 7, 14, 30 and 31, in that order. `irqOut` is the OR of the gated pending bits and follows the status by one clock.
- R10: With the enable register at 0, `irqOut` stays low whatever is pending.
- R11: Enable bits 5 to 12 and 16 to 18 are stored but never raise `irqOut`.
- R12: The status word is at offset `STATUS_OFS` (default 0) and the enable register is at `ENABLE_OFS` (default 4). A write to any other offset changes nothing, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| evtPulse | input | 32 | Event pulses, one per status position |
| bufLevel | input | 4 | Buffer levels: [3] Y empty, [2] X empty, [1] Y full, [0] X full |
| busClkRun | input | 1 | Card bus clock running |
| wcrcCodeIn | input | 2 | Write-CRC result code from the datapath |
| irqOut | output | 1 | Registered interrupt request |
| errSummary | output | 1 | OR of the error status bits |
| wcrcNoToken | output | 1 | Write-CRC error with no status token |
| wcrcMismatch | output | 1 | Write-CRC error with a wrong CRC |

## Verification
A sticky bit that is lost or wrongly kept shows up in the next status read. It also shows one clock later on `irqOut`, if that bit is enabled. A wrong gating pair shows as an interrupt that fails to appear, or appears for the wrong source, two edges after the event pulse. A code field that is not latched or not cleared shows at once on `wcrcNoToken` and `wcrcMismatch`, and in bits 10:9 of the next read.

// File: rtl/cardevt_pkg.sv
package cardevt_pkg;
  localparam int DATA_W = 32;
  localparam int EN_W   = 19;
  localparam int CODE_LO = 9;
  localparam int CRC_WR_BIT = 2;

  // positions that latch event pulses
  localparam logic [DATA_W-1:0] STICKY_MASK = 32'hC300_78EF;
  // response/data error group
  localparam logic [DATA_W-1:0] ERR_MASK = 32'h0000_002F;
  // enable bits that have an interrupt source
  localparam logic [EN_W-1:0] IRQ_EN_MASK = 19'h0_E01F;

  typedef struct packed {
    logic statusClr;
    logic enableLoad;
  } regStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_t;

  // status position gated by enable bit en, or -1 when none
  function automatic int gateSrc(input int en);
    case (en)
      0:  gateSrc = 11;
      1:  gateSrc = 12;
      2:  gateSrc = 13;
      3:  gateSrc = 6;
      4:  gateSrc = 7;
      13: gateSrc = 14;
      14: gateSrc = 30;
      15: gateSrc = 31;
      default: gateSrc = -1;
    endcase
  endfunction
endpackage

// File: rtl/cardevt_ctrl.sv
module cardevt_ctrl
  import cardevt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h0,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        stb,
  output rdSel_t            rdSel
);
  logic hitStatus;
  logic hitEnable;

  assign hitStatus = (regAddr == STATUS_OFS);
  assign hitEnable = (regAddr == ENABLE_OFS);

  always_comb begin
    stb.statusClr  = regWrEn && hitStatus;
    stb.enableLoad = regWrEn && hitEnable;
    if (hitStatus)      rdSel = RD_STATUS;
    else if (hitEnable) rdSel = RD_ENABLE;
    else                rdSel = RD_NONE;
  end
endmodule

// File: rtl/cardevt_dp.sv
module cardevt_dp
  import cardevt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtPulse,
  input  logic [3:0]        bufLevel,
  input  logic              busClkRun,
  input  logic [1:0]        wcrcCodeIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusWord,
  output logic [EN_W-1:0]   enableQ,
  output logic              irqOut,
  output logic              errSummary,
  output logic              wcrcNoToken,
  output logic              wcrcMismatch
);
  logic [DATA_W-1:0] stickyQ;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [1:0]        codeQ;
  logic [EN_W-1:0]   gated;

  assign setVec = evtPulse & STICKY_MASK;
  assign clrVec = stb.statusClr ? (wrData & STICKY_MASK) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
      codeQ   <= '0;
    end else begin
      stickyQ <= (stickyQ & ~clrVec) | setVec;
      if (setVec[CRC_WR_BIT])      codeQ <= wcrcCodeIn;
      else if (clrVec[CRC_WR_BIT]) codeQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enableQ <= '0;
    else if (stb.enableLoad) enableQ <= wrData[EN_W-1:0];
  end

  always_comb begin
    statusWord = stickyQ;
    statusWord[29:26] = bufLevel;
    statusWord[8] = busClkRun;
    statusWord[CODE_LO+1:CODE_LO] = codeQ;
  end

  for (genvar g = 0; g < EN_W; g++) begin : gen_gate
    localparam int SRC = gateSrc(g);
    if (SRC >= 0) begin : gen_src
      assign gated[g] = enableQ[g] & stickyQ[SRC];
    end else begin : gen_none
      assign gated[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |gated;
  end

  assign errSummary   = |(stickyQ & ERR_MASK);
  assign wcrcNoToken  = stickyQ[CRC_WR_BIT] && (codeQ == 2'd2);
  assign wcrcMismatch = stickyQ[CRC_WR_BIT] && (codeQ == 2'd1 || codeQ == 2'd3);

  always_comb begin
    case (rdSel)
      RD_STATUS: rdData = statusWord;
      RD_ENABLE: rdData = {{(DATA_W-EN_W){1'b0}}, enableQ};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/card_event_regs.sv
module card_event_regs
  import cardevt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h0,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [31:0]       evtPulse,
  input  logic [3:0]        bufLevel,
  input  logic              busClkRun,
  input  logic [1:0]        wcrcCodeIn,
  output logic              irqOut,
  output logic              errSummary,
  output logic              wcrcNoToken,
  output logic              wcrcMismatch
);
  regStrobe_t        stb;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] statusWord;
  logic [EN_W-1:0]   enableQ;

  cardevt_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS)
  ) i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .stb(stb), .rdSel(rdSel)
  );

  cardevt_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel),
    .wrData(regWrData), .evtPulse(evtPulse), .bufLevel(bufLevel),
    .busClkRun(busClkRun), .wcrcCodeIn(wcrcCodeIn), .rdData(regRdData),
    .statusWord(statusWord), .enableQ(enableQ), .irqOut(irqOut),
    .errSummary(errSummary), .wcrcNoToken(wcrcNoToken),
    .wcrcMismatch(wcrcMismatch)
  );
endmodule

// File: rtl/cardevt_chk.sv
module cardevt_chk
  import cardevt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] evtPulse,
  input logic [DATA_W-1:0] statusWord,
  input logic [EN_W-1:0]   enableQ,
  input logic              irqOut,
  input logic              errSummary,
  input logic              wcrcNoToken
);
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == STATUS_OFS) |=>
      ((statusWord & $past(statusWord & STICKY_MASK)) == $past(statusWord & STICKY_MASK))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & STICKY_MASK) != '0) |=>
      ((statusWord & $past(evtPulse & STICKY_MASK)) == $past(evtPulse & STICKY_MASK))); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enableQ) == '0) |-> !irqOut); // R10
  AST_IRQ_NEEDS_SOURCE_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(enableQ & IRQ_EN_MASK) != '0)); // R11
  AST_ERR_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSummary) |-> ($past(evtPulse & ERR_MASK) != '0)); // R7
  AST_NO_TOKEN_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    wcrcNoToken |-> statusWord[CRC_WR_BIT]); // R6
endmodule

bind card_event_regs cardevt_chk #(.ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .evtPulse(evtPulse), .statusWord(statusWord), .enableQ(enableQ),
  .irqOut(irqOut), .errSummary(errSummary), .wcrcNoToken(wcrcNoToken)
);

// File: tb/test_card_event_regs.sv
module test_card_event_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] ST = 6'h0;
  localparam logic [5:0] EN = 6'h4;
  localparam logic [31:0] STICKY = 32'hC300_78EF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] evtPulse = '0;
  logic [3:0] bufLevel = '0;
  logic busClkRun = 1'b0;
  logic [1:0] wcrcCodeIn = '0;
  logic irqOut, errSummary, wcrcNoToken, wcrcMismatch;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_event_regs i_card_event_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .bufLevel(bufLevel), .busClkRun(busClkRun), .wcrcCodeIn(wcrcCodeIn),
    .irqOut(irqOut), .errSummary(errSummary), .wcrcNoToken(wcrcNoToken),
    .wcrcMismatch(wcrcMismatch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk);
    evtPulse = m;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearAll();
    busWrite(ST, 32'hFFFF_FFFF);
    tick();
  endtask

  function automatic int srcOf(input int en);
    case (en)
      0: return 11; 1: return 12; 2: return 13; 3: return 6;
      4: return 7; 13: return 14; 14: return 30; default: return 31;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    busRead(ST, d); chk("R1 status after reset", d, '0);
    busRead(EN, d); chk("R1 enable after reset", d, '0);
    chk("R1 irq after reset", {31'b0, irqOut}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(STICKY);
    busRead(ST, d); chk("R2 all sticky set", d, STICKY);
    tick(); tick();
    busRead(ST, d); chk("R2 sticky held", d, STICKY);
    clearAll();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(32'h4000_3001);
    busWrite(ST, 32'h0000_2000);
    busRead(ST, d); chk("R3 partial clear", d, 32'h4000_1001);
    bufLevel = 4'b0101; busClkRun = 1'b1;
    busRead(ST, d);
    busWrite(ST, d);
    busRead(ST, d); chk("R3 write-back clears events", d & STICKY, 0);
    bufLevel = '0; busClkRun = 1'b0;
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(32'h0000_1000);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = ST; regWrData = 32'h0000_3000;
    evtPulse = 32'h0000_2000;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evtPulse = '0;
    busRead(ST, d); chk("R4 set beats clear", d, 32'h0000_2000);
    clearAll();
  endtask

  task automatic t_level();
    logic [31:0] d;
    bufLevel = 4'b1010; busClkRun = 1'b1;
    busRead(ST, d); chk("R5 levels live", d, 32'h2800_0100);
    busWrite(ST, 32'hFFFF_FFFF);
    bufLevel = 4'b0101; busClkRun = 1'b0;
    busRead(ST, d); chk("R5 level follows after write", d, 32'h1400_0000);
    pulse(~STICKY);
    busRead(ST, d); chk("R5 non-sticky pulses ignored", d, 32'h1400_0000);
    bufLevel = '0;
  endtask

  task automatic t_crc_code();
    logic [31:0] d;
    wcrcCodeIn = 2'd2;
    pulse(32'h4);
    busRead(ST, d); chk("R6 code 2 captured", d, 32'h0000_0404);
    chk("R6 no-token flag", {30'b0, wcrcNoToken, wcrcMismatch}, 32'h2);
    wcrcCodeIn = 2'd1; tick();
    busRead(ST, d); chk("R6 code held without event", d, 32'h0000_0404);
    busWrite(ST, 32'h4);
    busRead(ST, d); chk("R6 code cleared with bit", d, 0);
    chk("R6 flags cleared", {30'b0, wcrcNoToken, wcrcMismatch}, 0);
    wcrcCodeIn = 2'd3;
    pulse(32'h4);
    chk("R6 mismatch flag", {30'b0, wcrcNoToken, wcrcMismatch}, 32'h1);
    wcrcCodeIn = 2'd0;
    clearAll();
  endtask

  task automatic t_errsum();
    logic [31:0] one;
    int bits[5] = '{0, 1, 2, 3, 5};
    foreach (bits[i]) begin
      one = 32'h1 << bits[i];
      pulse(one);
      chk("R7 error summary set", {31'b0, errSummary}, 1);
      clearAll();
      chk("R7 error summary clear", {31'b0, errSummary}, 0);
    end
    pulse(32'h0000_3800);
    chk("R7 non-error bits ignored", {31'b0, errSummary}, 0);
    clearAll();
  endtask

  task automatic t_enable_reg();
    logic [31:0] d;
    busWrite(EN, 32'hFFFF_FFFF);
    busRead(EN, d); chk("R8 enable width", d, 32'h0007_FFFF);
    busWrite(EN, 32'h0005_A5A5);
    busRead(EN, d); chk("R8 enable pattern", d, 32'h0005_A5A5);
    busWrite(EN, 0);
  endtask

  task automatic t_irq_map();
    int ens[8] = '{0, 1, 2, 3, 4, 13, 14, 15};
    foreach (ens[i]) begin
      busWrite(EN, 32'h1 << ens[i]);
      pulse(32'h1 << srcOf(ens[i]));
      chk("R9 irq lags status", {31'b0, irqOut}, 0);
      tick();
      chk("R9 irq for mapped source", {31'b0, irqOut}, 1);
      busWrite(ST, 32'h1 << srcOf(ens[i]));
      tick();
      chk("R9 irq drops after clear", {31'b0, irqOut}, 0);
      busWrite(EN, STICKY & ~(32'h1 << srcOf(ens[i])));
      busWrite(EN, 32'h1 << ens[(i + 1) % 8]);
      pulse(32'h1 << srcOf(ens[i]));
      tick();
      chk("R9 other enable ignores source", {31'b0, irqOut}, 0);
      clearAll();
    end
    busWrite(EN, 0);
  endtask

  task automatic t_mask_all();
    busWrite(EN, 0);
    pulse(STICKY);
    tick(); tick();
    chk("R10 masked irq", {31'b0, irqOut}, 0);
    clearAll();
  endtask

  task automatic t_unmapped();
    busWrite(EN, 32'h0007_1FE0);
    pulse(STICKY);
    tick(); tick();
    chk("R11 unmapped enables", {31'b0, irqOut}, 0);
    busWrite(EN, 0);
    clearAll();
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    pulse(32'h0000_0001);
    busWrite(6'h8, 32'hFFFF_FFFF);
    busWrite(6'hC, 32'hFFFF_FFFF);
    busRead(ST, d); chk("R12 stray write keeps status", d, 32'h1);
    busRead(EN, d); chk("R12 stray write keeps enable", d, 0);
    busRead(6'h8, d); chk("R12 stray read zero", d, 0);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_sticky();
    t_w1c();
    t_set_wins();
    t_level();
    t_crc_code();
    t_errsum();
    t_enable_reg();
    t_irq_map();
    t_mask_all();
    t_unmapped();
    t_bad_addr();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule